// File: doc/BRIEF.md
# Ternary Longest-Prefix Lookup Table

This block is a small ternary lookup table of `ENTRIES` rows, each `WIDTH` digits wide. Every digit is 0, 1 or wildcard. A write port loads one addressed row with a value word and a care mask, and marks the row as live. A care bit of 1 makes the digit specific. A care bit of 0 turns the digit into a wildcard.

On every clock the search key is compared against all live rows at once. Each row drives its own match line. A selection stage then picks the winner among the matching rows. The winner is the row with the most specific digits, which is the longest prefix. If two rows tie, the lower row address wins. The hit flag and the winning row address are registered, so the result appears one cycle after the key. Care masks are expected to be contiguous: ones at the most-significant end, then zeros. Under that rule the count of care bits is the prefix length.

Top module: `tcam_lpm`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `hit` is 0 and `hit_addr` is 0. Reset marks every row as not live, and a row that is not live never matches.
- R2: A digit whose care bit is 0 matches both key values 0 and 1. A digit whose care bit is 1 matches only when the key bit equals the stored value bit.
- R3: A row matches only when every one of its `WIDTH` digits matches. A single differing specific bit makes the row miss.
- R4: When several rows match, the reported row is the one with the largest number of care bits.
- R5: When matching rows tie on care-bit count, the lowest row address among them is reported.
- R6: When no live row matches, `hit` is 0 and `hit_addr` is 0.
- R7: `hit` and `hit_addr` reflect the key presented on `key` in the previous cycle, and change only at a clock edge.
- R8: A write is seen by searches whose key is presented from the following cycle on. A search in the same cycle as the write sees the old contents.
- R9: A write replaces the value, care mask and prefix length of the addressed row only. All other rows keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one row |
| wr_addr | input | $clog2(ENTRIES) | Row written |
| wr_value | input | WIDTH | Value bits of the row |
| wr_care | input | WIDTH | Care mask (1 = specific digit, 0 = wildcard), contiguous from the MSB |
| key | input | WIDTH | Search key, compared every cycle |
| hit | output | 1 | Registered: some live row matched the previous key |
| hit_addr | output | $clog2(ENTRIES) | Registered address of the winning row, 0 on a miss |

## Verification
The assertions take for granted that every care mask written is contiguous from the MSB. One assertion guards this on the write port, because prefix length only equals the care-bit count under that rule. They also take for granted that `wr_addr` stays below `ENTRIES`. The stimulus writes only masks of the form ones-then-zeros, and only row addresses 0 to 7. It also sets up overlapping prefixes, equal-length ties, a full-wildcard row and a search in the same cycle as a write, so the winner checks see real contention.

// File: rtl/tcam_lpm_pkg.sv
`timescale 1ns/1ps
package tcam_lpm_pkg;
  // Number of set bits in a word of up to 64 bits.
  function automatic logic [6:0] ones64(input logic [63:0] v);
    logic [6:0] n;
    n = '0;
    for (int i = 0; i < 64; i++) n = n + {6'd0, v[i]};
    return n;
  endfunction
endpackage

// File: rtl/tcam_row.sv
`timescale 1ns/1ps
module tcam_row #(
  parameter int WIDTH = 8,
  parameter int CW    = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [WIDTH-1:0] wr_value,
  input  logic [WIDTH-1:0] wr_care,
  input  logic [WIDTH-1:0] key,
  output logic             match,
  output logic [CW-1:0]    plen
);
  import tcam_lpm_pkg::*;

  logic [WIDTH-1:0] val_q, care_q;
  logic [CW-1:0]    len_q;
  logic             live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      val_q  <= '0;
      care_q <= '0;
      len_q  <= '0;
    end else if (we) begin
      live_q <= 1'b1;
      val_q  <= wr_value & wr_care;
      care_q <= wr_care;
      len_q  <= CW'(ones64(64'(wr_care)));
    end
  end

  // Chain of per-digit compares: a wildcard digit always agrees.
  logic [WIDTH-1:0] digit_ok;
  for (genvar d = 0; d < WIDTH; d++) begin : g_digit
    assign digit_ok[d] = ~care_q[d] | (key[d] == val_q[d]);
  end

  assign match = live_q & (&digit_ok);
  assign plen  = len_q;

  logic [WIDTH-1:0] inv_care;
  assign inv_care = ~wr_care;

  // R9
  // write_lands_chk
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> (care_q == $past(wr_care)) && (val_q == $past(wr_value & wr_care)) && live_q);

  // R1
  // dead_row_chk
  dead_row_chk: assert property (@(posedge clk) disable iff (rst)
    !live_q |-> !match);

  // R4
  // contig_mask_chk
  contig_mask_chk: assert property (@(posedge clk) disable iff (rst)
    we |-> ((inv_care & (inv_care + 1'b1)) == '0));
endmodule

// File: rtl/tcam_prefix_pick.sv
`timescale 1ns/1ps
module tcam_prefix_pick #(
  parameter int ENTRIES = 8,
  parameter int CW      = 4,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]         lines,
  input  logic [ENTRIES-1:0][CW-1:0] lens,
  output logic                       any,
  output logic [AW-1:0]              idx
);
  logic [CW-1:0] best;

  // Strict "greater than" keeps the lower address on a tie.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lines[i] && (!any || lens[i] > best)) begin
        any  = 1'b1;
        idx  = AW'(i);
        best = lens[i];
      end
    end
  end
endmodule

// File: rtl/tcam_lpm.sv
`timescale 1ns/1ps
module tcam_lpm #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 8,
  parameter int AW      = $clog2(ENTRIES),
  parameter int CW      = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_value,
  input  logic [WIDTH-1:0] wr_care,
  input  logic [WIDTH-1:0] key,
  output logic             hit,
  output logic [AW-1:0]    hit_addr
);
  logic [ENTRIES-1:0]         lines;
  logic [ENTRIES-1:0][CW-1:0] lens;
  logic                       pick_any;
  logic [AW-1:0]              pick_idx;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    tcam_row #(.WIDTH(WIDTH), .CW(CW)) u_row (
      .clk      (clk),
      .rst      (rst),
      .we       (wr_en && (wr_addr == AW'(g))),
      .wr_value (wr_value),
      .wr_care  (wr_care),
      .key      (key),
      .match    (lines[g]),
      .plen     (lens[g])
    );

    // R4
    // longest_wins_chk
    longest_wins_chk: assert property (@(posedge clk) disable iff (rst)
      lines[g] |-> pick_any && (lens[g] <= lens[pick_idx]));

    // R5
    // tie_low_chk
    tie_low_chk: assert property (@(posedge clk) disable iff (rst)
      (lines[g] && lens[g] == lens[pick_idx]) |-> (pick_idx <= AW'(g)));
  end

  tcam_prefix_pick #(.ENTRIES(ENTRIES), .CW(CW), .AW(AW)) u_pick (
    .lines (lines),
    .lens  (lens),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit      <= 1'b0;
      hit_addr <= '0;
    end else begin
      hit      <= pick_any;
      hit_addr <= pick_any ? pick_idx : '0;
    end
  end

  // R3
  // winner_line_chk
  winner_line_chk: assert property (@(posedge clk) disable iff (rst)
    pick_any |-> lines[pick_idx]);

  // R7
  // hit_latency_chk
  hit_latency_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hit == $past(|lines)));

  // R6
  // miss_zero_chk
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_addr == '0));
endmodule

// File: tb/tcam_lpm_test.sv
`timescale 1ns/1ps
module tcam_lpm_test;
  localparam int ENTRIES = 8;
  localparam int WIDTH   = 8;
  localparam int AW      = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WIDTH-1:0] wr_value = '0, wr_care = '0, key = '0;
  logic hit;
  logic [AW-1:0] hit_addr;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  tcam_lpm #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_value(wr_value), .wr_care(wr_care), .key(key),
    .hit(hit), .hit_addr(hit_addr)
  );

  // {key, expected hit, expected address}
  localparam logic [11:0] VEC [9] = '{
    {8'h6D, 1'b1, 3'd1},  // R4: rows 0,1,2,6 match, row 1 longest
    {8'h65, 1'b1, 3'd0},  // R4: row 1 misses on bit 3, row 0 longest
    {8'h75, 1'b1, 3'd2},  // R2: only the 3-digit prefix row and row 6
    {8'hAA, 1'b1, 3'd3},  // R3: exact full-width row
    {8'hAB, 1'b1, 3'd6},  // R3: one bit off the exact row
    {8'hC3, 1'b1, 3'd4},  // R5: rows 4 and 5 tie, lower wins
    {8'hFF, 1'b1, 3'd4},  // R5: tie again with a different key
    {8'h00, 1'b1, 3'd6},  // R2: all-wildcard row only
    {8'h3C, 1'b1, 3'd6}   // R2: all-wildcard row only
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_row(input logic [AW-1:0] a, input logic [7:0] v, input logic [7:0] c);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_value = v; wr_care = c;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Key is applied at a falling edge and the result is read at the next falling edge.
  task automatic search(input logic [7:0] k, input bit eh, input logic [AW-1:0] ea, input string req);
    @(negedge clk);
    key = k;
    @(negedge clk);
    check(hit == eh, req, int'(hit), int'(eh));
    check(hit_addr == ea, req, int'(hit_addr), int'(ea));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is high
    check(hit == 1'b0 && hit_addr == '0, "R1", int'({hit, hit_addr}), 0);
    rst = 1'b0;

    // R1: no row is live after reset
    search(8'h00, 1'b0, 3'd0, "R1");

    write_row(3'd0, 8'h60, 8'hF0);
    write_row(3'd1, 8'h68, 8'hF8);
    write_row(3'd2, 8'h60, 8'hE0);
    write_row(3'd3, 8'hAA, 8'hFF);
    write_row(3'd4, 8'hC0, 8'hC0);
    write_row(3'd5, 8'hC0, 8'hC0);

    // R6: no live row matches
    search(8'h00, 1'b0, 3'd0, "R6");
    search(8'h3C, 1'b0, 3'd0, "R6");

    write_row(3'd6, 8'h00, 8'h00);

    for (int i = 0; i < 9; i++) begin
      search(VEC[i][11:4], VEC[i][3], VEC[i][2:0], "R4/R5/R2/R3 table");
    end

    // R7: the output keeps the old result until the next clock edge
    @(negedge clk);
    key = 8'hAA;
    #1;
    check(hit_addr == 3'd6, "R7", int'(hit_addr), 6);
    @(negedge clk);
    check(hit_addr == 3'd3, "R7", int'(hit_addr), 3);

    // R9: rewriting row 4 leaves row 5 in place
    write_row(3'd4, 8'hF0, 8'hF0);
    search(8'hC3, 1'b1, 3'd5, "R9");
    search(8'hF3, 1'b1, 3'd4, "R9");
    search(8'hAA, 1'b1, 3'd3, "R9");

    // R8: a search in the same cycle as the write sees the old contents
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd7; wr_value = 8'h00; wr_care = 8'hFF; key = 8'h00;
    @(negedge clk);
    wr_en = 1'b0;
    check(hit_addr == 3'd6, "R8", int'(hit_addr), 6);
    @(negedge clk);
    check(hit == 1'b1 && hit_addr == 3'd7, "R8", int'(hit_addr), 7);

    // R1: reset in mid-run clears outputs and all rows
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(hit == 1'b0 && hit_addr == '0, "R1", int'({hit, hit_addr}), 0);
    rst = 1'b0;
    search(8'h00, 1'b0, 3'd0, "R1");
    search(8'hAA, 1'b0, 3'd0, "R1");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule